// File: doc/BRIEF.md
# Predicated Vector Magnitude Compare

This unit compares the absolute values of two vectors of IEEE-754 floating-point lanes, one lane at a time. The lanes are 16, 32 or 64 bits wide, chosen by a 2-bit size code. A byte-granular governing predicate decides which lanes take part. For each lane the unit writes one boolean into a byte-granular destination predicate. The test is either strictly greater-than or greater-than-or-equal. To get less-than or less-or-equal, the caller swaps the two source vectors.

The result is registered. One clock after an input strobe, the unit presents the destination predicate together with an output strobe and a flag that marks a reserved size code. Between strobes the outputs hold their last values. The unit writes no condition flags.

Top module: `mag_cmp_pred`

## Requirements
- R1: Size code 2'b01 splits each source into 16-bit half-precision lanes (5-bit exponent). Lane l occupies source bits [16l+15:16l] and destination chunk bits [2l+1:2l].
- R2: Size code 2'b10 gives 32-bit single-precision lanes (8-bit exponent). Lane l uses source bits [32l+31:32l] and destination chunk bits [4l+3:4l].
- R3: Size code 2'b11 gives 64-bit double-precision lanes (11-bit exponent). Lane l uses source bits [64l+63:64l] and destination chunk bits [8l+7:8l].
- R4: Size code 2'b00 is reserved. The registered illegal flag is 1 and the whole destination predicate is zero. For any other code the flag is 0.
- R5: A lane is active exactly when the predicate bit at the lowest position of its chunk is 1. The other predicate bits of the chunk are ignored. An inactive lane writes all zeros to its chunk.
- R6: An active lane places its result in the lowest bit of its chunk. All higher bits of that chunk are 0.
- R7: The sign bits of both operands are ignored. Only magnitudes are compared, so +0 and -0 are equal. Subnormals order below normals, and infinity orders above every finite value.
- R8: When the op select is 0, an active lane gives 1 only if |A| > |B|. When the op select is 1, it gives 1 if |A| >= |B|.
- R9: If either operand is a NaN (exponent all ones, fraction nonzero), the lane result is 0 for both operations.
- R10: The output strobe is the input strobe delayed by one clock. The destination predicate and the illegal flag load only on a strobed cycle and hold otherwise.
- R11: A synchronous active-low reset clears the output strobe, the destination predicate and the illegal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| src_a | input | VEC_BITS | First source vector |
| src_b | input | VEC_BITS | Second source vector |
| pred_in | input | VEC_BITS/8 | Governing predicate, one bit per byte |
| size_code | input | 2 | Lane size code |
| or_equal | input | 1 | 0: greater-than, 1: greater-or-equal |
| out_valid | output | 1 | Output strobe |
| pred_out | output | VEC_BITS/8 | Destination predicate |
| bad_size | output | 1 | Reserved size code seen |

## Verification
The bench builds the unit with the default 128-bit vector. That gives eight half-precision lanes, four single-precision lanes and two double-precision lanes. Every size therefore has several lanes and chunk boundaries inside one vector. A single vector can mix zeros of both signs, subnormals, infinities, NaNs and predicates whose upper chunk bits disagree with the lowest bit. Operand swapping is exercised so that the derived less-than form is covered.

// File: rtl/mcp_pkg.sv
// Package: shared size codes and lane-format constants for the magnitude compare.
// Assumes IEEE-754 binary16/32/64 layouts.
package mcp_pkg;
    typedef enum logic [1:0] {
        SZ_RSVD = 2'b00,
        SZ_HALF = 2'b01,
        SZ_SNGL = 2'b10,
        SZ_DBL  = 2'b11
    } size_e;

    localparam int HALF_W  = 16;
    localparam int HALF_EW = 5;
    localparam int SNGL_W  = 32;
    localparam int SNGL_EW = 8;
    localparam int DBL_W   = 64;
    localparam int DBL_EW  = 11;
endpackage

// File: rtl/abs_lane_cmp.sv
// Module: compares the magnitudes of two floating-point values of width W.
// Assumes exponent width EW and an IEEE layout. A NaN on either side gives 0.
module abs_lane_cmp #(
    parameter int W  = 32,
    parameter int EW = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         or_equal,
    output logic         hit
);
    localparam int FW = W - 1 - EW;
    localparam logic [W-1:0] MAG_MASK = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] mag_a, mag_b;
    logic         nan_a, nan_b;

    // Strip signs, detect NaNs and perform the unsigned magnitude compare.
    always_comb begin
        mag_a = op_a & MAG_MASK;
        mag_b = op_b & MAG_MASK;
        nan_a = (&mag_a[W-2:FW]) && (|mag_a[FW-1:0]);
        nan_b = (&mag_b[W-2:FW]) && (|mag_b[FW-1:0]);
        if (nan_a || nan_b)
            hit = 1'b0;
        else if (or_equal)
            hit = (mag_a >= mag_b);
        else
            hit = (mag_a > mag_b);
    end
endmodule

// File: rtl/lane_group.sv
// Module: splits the vectors into lanes of width W and builds the formatted
// destination predicate for that lane size. Assumes VEC_BITS is a multiple of W.
module lane_group #(
    parameter int VEC_BITS = 128,
    parameter int W        = 32,
    parameter int EW       = 8
) (
    input  logic [VEC_BITS-1:0]   src_a,
    input  logic [VEC_BITS-1:0]   src_b,
    input  logic [VEC_BITS/8-1:0] pred_in,
    input  logic                  or_equal,
    output logic [VEC_BITS/8-1:0] chunks
);
    localparam int NB    = VEC_BITS / 8;
    localparam int LANES = VEC_BITS / W;
    localparam int CB    = W / 8;

    logic [LANES-1:0] hits;
    logic [NB-1:0]    placed;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        abs_lane_cmp #(.W(W), .EW(EW)) u_cmp (
            .op_a     (src_a[l*W +: W]),
            .op_b     (src_b[l*W +: W]),
            .or_equal (or_equal),
            .hit      (hits[l])
        );
        // Put the lane result at the lowest bit of its chunk.
        assign placed[l*CB +: CB] = {{(CB-1){1'b0}}, hits[l]};
    end

    // The governing bit and the placed result share the low chunk position.
    assign chunks = pred_in & placed;
endmodule

// File: rtl/mag_cmp_pred.sv
// Module: top of the predicated magnitude compare. It selects the lane-size
// variant, rejects the reserved size code and registers the result.
// Assumes the inputs are stable around the strobed clock edge.
module mag_cmp_pred
    import mcp_pkg::*;
#(
    parameter int VEC_BITS = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [VEC_BITS-1:0]   src_a,
    input  logic [VEC_BITS-1:0]   src_b,
    input  logic [VEC_BITS/8-1:0] pred_in,
    input  logic [1:0]            size_code,
    input  logic                  or_equal,
    output logic                  out_valid,
    output logic [VEC_BITS/8-1:0] pred_out,
    output logic                  bad_size
);
    localparam int NB = VEC_BITS / 8;

    logic [NB-1:0] res_h, res_s, res_d, res_sel;
    logic          rsvd;

    lane_group #(.VEC_BITS(VEC_BITS), .W(HALF_W), .EW(HALF_EW)) u_half (
        .src_a(src_a), .src_b(src_b), .pred_in(pred_in),
        .or_equal(or_equal), .chunks(res_h)
    );
    lane_group #(.VEC_BITS(VEC_BITS), .W(SNGL_W), .EW(SNGL_EW)) u_sngl (
        .src_a(src_a), .src_b(src_b), .pred_in(pred_in),
        .or_equal(or_equal), .chunks(res_s)
    );
    lane_group #(.VEC_BITS(VEC_BITS), .W(DBL_W), .EW(DBL_EW)) u_dbl (
        .src_a(src_a), .src_b(src_b), .pred_in(pred_in),
        .or_equal(or_equal), .chunks(res_d)
    );

    // Pick the variant for the requested size; the reserved code yields zeros.
    always_comb begin
        rsvd = 1'b0;
        unique case (size_e'(size_code))
            SZ_HALF: res_sel = res_h;
            SZ_SNGL: res_sel = res_s;
            SZ_DBL:  res_sel = res_d;
            default: begin
                res_sel = '0;
                rsvd    = 1'b1;
            end
        endcase
    end

    // Register the result on a strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            pred_out  <= '0;
            bad_size  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                pred_out <= res_sel;
                bad_size <= rsvd;
            end
        end
    end
endmodule

// File: rtl/mcp_check.sv
// Module: assertion checker for mag_cmp_pred, attached by bind below.
// Assumes the same VEC_BITS as the instance it watches.
module mcp_check #(
    parameter int VEC_BITS = 128
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [VEC_BITS/8-1:0] pred_in,
    input logic [1:0]            size_code,
    input logic                  out_valid,
    input logic [VEC_BITS/8-1:0] pred_out,
    input logic                  bad_size
);
    localparam int NB = VEC_BITS / 8;

    function automatic logic [NB-1:0] low_marks(int step);
        logic [NB-1:0] m = '0;
        for (int i = 0; i < NB; i += step) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [NB-1:0] LOW_H = low_marks(2);
    localparam logic [NB-1:0] LOW_S = low_marks(4);
    localparam logic [NB-1:0] LOW_D = low_marks(8);

    assert_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_nostrobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(pred_out) && $stable(bad_size));
    assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && size_code == 2'b00 |=> bad_size && pred_out == '0);
    assert_legal_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && size_code != 2'b00 |=> !bad_size);
    assert_inactive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (pred_out & ~$past(pred_in)) == '0);
    assert_chunk_h_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && size_code == 2'b01 |=> (pred_out & ~LOW_H) == '0);
    assert_chunk_s_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && size_code == 2'b10 |=> (pred_out & ~LOW_S) == '0);
    assert_chunk_d_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && size_code == 2'b11 |=> (pred_out & ~LOW_D) == '0);
    assert_reset_R11: assert property (@(posedge clk)
        !rst_n |=> !out_valid && pred_out == '0 && !bad_size);
endmodule

bind mag_cmp_pred mcp_check #(.VEC_BITS(VEC_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pred_in(pred_in),
    .size_code(size_code), .out_valid(out_valid), .pred_out(pred_out),
    .bad_size(bad_size)
);

// File: tb/sim_mag_cmp_pred.sv
// Bench: table-driven vectors, then directed hold and reset checks.
module sim_mag_cmp_pred;
    localparam int VB = 128;
    localparam int NB = VB / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [VB-1:0] src_a = '0, src_b = '0;
    logic [NB-1:0] pred_in = '0;
    logic [1:0] size_code = 2'b00;
    logic or_equal = 1'b0;
    logic out_valid, bad_size;
    logic [NB-1:0] pred_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mag_cmp_pred #(.VEC_BITS(VB)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a),
        .src_b(src_b), .pred_in(pred_in), .size_code(size_code),
        .or_equal(or_equal), .out_valid(out_valid), .pred_out(pred_out),
        .bad_size(bad_size)
    );

    typedef struct packed {
        logic [1:0]    sz;
        logic          ge;
        logic [VB-1:0] a;
        logic [VB-1:0] b;
        logic [NB-1:0] pr;
        logic [NB-1:0] ex;
        logic          bad;
    } vec_t;

    localparam vec_t TBL [9] = '{
        // R2 R8 R9: single, GT, NaN in lane 3
        '{2'b10, 1'b0, 128'h7FC00000_40000000_BF800000_3F800000,
          128'h3F800000_BF800000_3F800000_C0000000, 16'hFFFF, 16'h0100, 1'b0},
        // R2 R7 R8: single, GE, equal magnitudes of opposite sign
        '{2'b10, 1'b1, 128'h7FC00000_40000000_BF800000_3F800000,
          128'h3F800000_BF800000_3F800000_C0000000, 16'hFFFF, 16'h0110, 1'b0},
        // R5: only the lowest chunk bit governs
        '{2'b10, 1'b1, 128'h7FC00000_40000000_BF800000_3F800000,
          128'h3F800000_BF800000_3F800000_C0000000, 16'h010E, 16'h0100, 1'b0},
        // R8: swapped operands give the less-than form
        '{2'b10, 1'b0, 128'h3F800000_BF800000_3F800000_C0000000,
          128'h7FC00000_40000000_BF800000_3F800000, 16'hFFFF, 16'h0001, 1'b0},
        // R1 R7 R9: half, GE, zeros, inf, NaN, subnormal
        '{2'b01, 1'b1, 128'h0000C200400000017E007C0080003C00,
          128'h00004000C40000003C007BFF0000BC00, 16'hFFFF, 16'h5115, 1'b0},
        // R1 R6 R8: half, GT
        '{2'b01, 1'b0, 128'h0000C200400000017E007C0080003C00,
          128'h00004000C40000003C007BFF0000BC00, 16'hFFFF, 16'h1110, 1'b0},
        // R3 R9: double, GT, signalling NaN in lane 1
        '{2'b11, 1'b0, 128'h7FF0000000000001_BFF0000000000000,
          128'h0000000000000000_3FEFFFFFFFFFFFFF, 16'hFFFF, 16'h0001, 1'b0},
        // R3 R5 R7: double, GE, -0 vs +0, lane 1 inactive
        '{2'b11, 1'b1, 128'h4000000000000000_8000000000000000,
          128'h0, 16'hFE01, 16'h0001, 1'b0},
        // R4: reserved size code
        '{2'b00, 1'b1, 128'h7FC00000_40000000_BF800000_3F800000,
          128'h3F800000_BF800000_3F800000_C0000000, 16'hFFFF, 16'h0000, 1'b1}
    };

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_vec(string req, logic [NB-1:0] act, logic [NB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(vec_t v);
        @(negedge clk);
        size_code = v.sz; or_equal = v.ge; src_a = v.a; src_b = v.b;
        pred_in = v.pr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check_bit("R11 out_valid", out_valid, 1'b0);
        check_vec("R11 pred_out", pred_out, '0);
        check_bit("R11 bad_size", bad_size, 1'b0);
        rst_n = 1'b1;

        foreach (TBL[i]) begin
            apply(TBL[i]);
            check_bit("R10 strobe", out_valid, 1'b1);
            check_vec($sformatf("table %0d result", i), pred_out, TBL[i].ex);
            check_bit("R4 flag", bad_size, TBL[i].bad);
        end

        // R10: outputs hold while unstrobed inputs change
        apply(TBL[4]);
        @(negedge clk);
        src_a = '0; src_b = '1; size_code = 2'b00; pred_in = '0;
        @(negedge clk);
        check_bit("R10 idle strobe", out_valid, 1'b0);
        check_vec("R10 hold result", pred_out, 16'h5115);
        check_bit("R10 hold flag", bad_size, 1'b0);

        // R11: reset clears a loaded result
        apply(TBL[8]);
        check_bit("R4 flag before reset", bad_size, 1'b1);
        apply(TBL[1]);
        rst_n = 1'b0;
        @(negedge clk);
        check_vec("R11 cleared", pred_out, '0);
        check_bit("R11 strobe cleared", out_valid, 1'b0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule